// File: doc/BRIEF.md
# Polled Two-Level Interrupt Arbiter

This block decides, once per machine cycle, whether the processor core should take an interrupt, and if so which one. Every source flag is masked by its own enable bit and by a global enable. The surviving requests are split into a high and a low priority group by a per-source priority bit. The winner is the lowest-numbered request in the highest group that is not blocked by the routine currently being serviced. A grant is a single-clock strobe to the core that carries the routine's vector address. The same strobe sets the in-service marker for the winning level. Where the source's flag is of a self-clearing kind, the strobe also sends a one-clock clear pulse back to the peripheral that owns it.

A grant is only possible on the last machine cycle of an instruction. It is refused when that instruction is a return-from-interrupt or a write to one of the interrupt control registers. The arbiter keeps no pending state. A request that is refused is judged afresh in the next poll, and if its flag has dropped by then it is never served. A return-from-interrupt that completes releases the higher of the two active in-service levels, so the high level can nest on top of the low one. The core performs the call itself, which takes several machine cycles. The arbiter only issues the request that starts it.

Top module: `irq_poll_arb`

## Requirements
- R1: After reset, `vec_req`, `flag_clr` and `svc_lvl` are all zero.
- R2: A poll happens only on a clock where `cyc_en` and `last_cyc` are 1 and both `ret_irq` and `ctl_wr` are 0. When the poll grants, `vec_req` is 1 on the following clock for exactly one clock. With `last_cyc` at 0 there is no grant.
- R3: Source i takes part only when `req[i]`, `irq_en[i]` and `glb_en` are all 1.
- R4: A source with `prio_hi[i]`=1 beats every source with `prio_hi[i]`=0. Within one group, the lowest index wins.
- R5: No grant is given while the high level is in service. A low-group source is granted only when neither level is in service. A high-group source may be granted while only the low level is in service.
- R6: On a grant, `vec_addr` = 0x0003 + 8 × (index of the winner).
- R7: A grant sets `svc_lvl[1]` for a high-group winner or `svc_lvl[0]` for a low-group winner, on the same clock as `vec_req`.
- R8: On a clock with `cyc_en`, `last_cyc` and `ret_irq` all 1, `svc_lvl[1]` is cleared if it is set, and otherwise `svc_lvl[0]` is cleared. No grant occurs on that poll. With both levels idle, `svc_lvl` stays 0.
- R9: `flag_clr` is one-hot with `vec_req` and marks the winner only for clearable sources. Timer sources 1 and 3 are always cleared. External sources 0, 2 and 6 are cleared only when `edge_mode[i]`=1. Sources 4, 5 and 7 are never cleared. At all other times `flag_clr` is 0.
- R10: A request that is refused and then drops before the next eligible poll is never granted.
- R11: A poll with `ctl_wr`=1 grants nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_en | input | 1 | Machine-cycle strobe; polls take place only when it is 1 |
| last_cyc | input | 1 | Current machine cycle ends the instruction |
| ret_irq | input | 1 | Current instruction is return-from-interrupt |
| ctl_wr | input | 1 | Current instruction writes an interrupt control register |
| req | input | N | Source request flags |
| irq_en | input | N | Per-source enable |
| glb_en | input | 1 | Global enable |
| prio_hi | input | N | Per-source high-priority select |
| edge_mode | input | N | Per-source edge-triggered configuration (external sources) |
| vec_req | output | 1 | One-clock request to the core to perform the hardware call |
| vec_addr | output | 16 | Vector address of the granted source |
| flag_clr | output | N | One-clock clear pulse to the winning source's flag |
| svc_lvl | output | 2 | In-service markers: bit 1 high level, bit 0 low level |

## Verification
Every result is registered, so a poll presented before a rising edge shows its grant, vector address, clear pulse and in-service change immediately after that edge. The grant strobe falls again one clock later. The bench therefore drives each poll at a falling edge, lets one rising edge pass, and reads all outputs at the next falling edge. It then idles `cyc_en` for a clock and confirms that the strobe and the clear pulse have returned to zero. Refused polls are read at the same point, where `vec_req` must be 0 and `svc_lvl` unchanged.

// File: rtl/irq_poll_pkg.sv
package irq_poll_pkg;
  localparam int VEC_BASE = 3;
  localparam int VEC_SHIFT = 3;

  function automatic logic [15:0] vec_addr_of(input logic [7:0] idx);
    return 16'(VEC_BASE) + (16'(idx) << VEC_SHIFT);
  endfunction

  function automatic logic [1:0] svc_after_ret(input logic [1:0] svc);
    if (svc[1]) return {1'b0, svc[0]};
    return 2'b00;
  endfunction
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  cand,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) idx = IW'(i);
    end
    any = |cand;
  end
endmodule

// File: rtl/irq_svc_state.sv
module irq_svc_state (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_hi,
  input  logic       set_lo,
  input  logic       ret_evt,
  output logic [1:0] svc
);
  import irq_poll_pkg::*;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       svc <= 2'b00;
    else if (ret_evt) svc <= svc_after_ret(svc);
    else if (set_hi)  svc <= svc | 2'b10;
    else if (set_lo)  svc <= svc | 2'b01;
  end
endmodule

// File: rtl/irq_poll_arb.sv
module irq_poll_arb #(
  parameter int          N         = 8,
  parameter logic [N-1:0] AUTO_CLR = 8'b0000_1010,
  parameter logic [N-1:0] EXT_SRC  = 8'b0100_0101,
  localparam int         IW        = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cyc_en,
  input  logic         last_cyc,
  input  logic         ret_irq,
  input  logic         ctl_wr,
  input  logic [N-1:0] req,
  input  logic [N-1:0] irq_en,
  input  logic         glb_en,
  input  logic [N-1:0] prio_hi,
  input  logic [N-1:0] edge_mode,
  output logic         vec_req,
  output logic [15:0]  vec_addr,
  output logic [N-1:0] flag_clr,
  output logic [1:0]   svc_lvl
);
  import irq_poll_pkg::*;

  logic [N-1:0]  active;
  logic [N-1:0]  grp_cand [2];
  logic [1:0]    grp_any;
  logic [IW-1:0] grp_idx [2];
  logic          poll_ok, ret_evt, grant_hi, grant_lo, grant;
  logic [IW-1:0] win_idx;
  logic [N-1:0]  win_oh, clr_mask;

  assign active      = req & irq_en & {N{glb_en}};
  assign grp_cand[1] = active & prio_hi;
  assign grp_cand[0] = active & ~prio_hi;

  for (genvar lv = 0; lv < 2; lv++) begin : g_lvl
    irq_pick #(.N(N)) u_pick (
      .cand (grp_cand[lv]),
      .any  (grp_any[lv]),
      .idx  (grp_idx[lv])
    );
  end

  assign poll_ok  = cyc_en & last_cyc & ~ret_irq & ~ctl_wr;
  assign ret_evt  = cyc_en & last_cyc & ret_irq;
  assign grant_hi = poll_ok & grp_any[1] & ~svc_lvl[1];
  assign grant_lo = poll_ok & ~grp_any[1] & grp_any[0] & (svc_lvl == 2'b00);
  assign grant    = grant_hi | grant_lo;
  assign win_idx  = grant_hi ? grp_idx[1] : grp_idx[0];
  assign win_oh   = N'(1) << win_idx;
  assign clr_mask = AUTO_CLR | (EXT_SRC & edge_mode);

  irq_svc_state u_svc (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_hi  (grant_hi),
    .set_lo  (grant_lo),
    .ret_evt (ret_evt),
    .svc     (svc_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_req  <= 1'b0;
      vec_addr <= '0;
      flag_clr <= '0;
    end else begin
      vec_req  <= grant;
      flag_clr <= grant ? (win_oh & clr_mask) : '0;
      if (grant) vec_addr <= vec_addr_of(8'(win_idx));
    end
  end
endmodule

// File: rtl/irq_poll_arb_chk.sv
module irq_poll_arb_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cyc_en,
  input logic         last_cyc,
  input logic         ret_irq,
  input logic         ctl_wr,
  input logic         vec_req,
  input logic [15:0]  vec_addr,
  input logic [N-1:0] flag_clr,
  input logic [1:0]   svc_lvl
);
  AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> $past(cyc_en && last_cyc && !ret_irq && !ctl_wr)); // R2
  AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |=> !vec_req); // R2
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_clr)); // R9
  AST_CLR_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr != '0) |-> vec_req); // R9
  AST_HI_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> !$past(svc_lvl[1])); // R5
  AST_GRANT_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> (svc_lvl != 2'b00)); // R7
  AST_VEC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> (vec_addr[2:0] == 3'd3)); // R6
endmodule

bind irq_poll_arb irq_poll_arb_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .last_cyc(last_cyc),
  .ret_irq(ret_irq), .ctl_wr(ctl_wr), .vec_req(vec_req),
  .vec_addr(vec_addr), .flag_clr(flag_clr), .svc_lvl(svc_lvl)
);

// File: tb/irq_poll_arb_bench.sv
module irq_poll_arb_bench;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc_en = 0, last_cyc = 0, ret_irq = 0, ctl_wr = 0, glb_en = 0;
  logic [N-1:0] req = '0, irq_en = '0, prio_hi = '0, edge_mode = '0;
  logic vec_req;
  logic [15:0] vec_addr;
  logic [N-1:0] flag_clr;
  logic [1:0] svc_lvl;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  irq_poll_arb u_irq_poll_arb (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .last_cyc(last_cyc),
    .ret_irq(ret_irq), .ctl_wr(ctl_wr), .req(req), .irq_en(irq_en),
    .glb_en(glb_en), .prio_hi(prio_hi), .edge_mode(edge_mode),
    .vec_req(vec_req), .vec_addr(vec_addr), .flag_clr(flag_clr),
    .svc_lvl(svc_lvl)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_addr(input int i);
    return 16'(3 + i * 8);
  endfunction

  // present one poll at a falling edge, let one rising edge pass, return at falling edge
  task automatic poll(input bit last, input bit reti, input bit wr);
    cyc_en = 1; last_cyc = last; ret_irq = reti; ctl_wr = wr;
    @(posedge clk); @(negedge clk);
    cyc_en = 0; last_cyc = 0; ret_irq = 0; ctl_wr = 0;
  endtask

  task automatic expect_grant(input string tag, input int idx, input logic [N-1:0] clr, input logic [1:0] svc);
    chk(vec_req === 1'b1, {tag, " vec_req"}, vec_req, 1);
    chk(vec_addr === exp_addr(idx), {tag, " vec_addr R6"}, vec_addr, exp_addr(idx));
    chk(flag_clr === clr, {tag, " flag_clr R9"}, flag_clr, clr);
    chk(svc_lvl === svc, {tag, " svc_lvl R7"}, svc_lvl, svc);
    @(posedge clk); @(negedge clk);
    chk(vec_req === 1'b0 && flag_clr === '0, {tag, " pulse ends R2"}, {vec_req, flag_clr}, 0);
  endtask

  task automatic expect_none(input string tag, input logic [1:0] svc);
    chk(vec_req === 1'b0, {tag, " no grant"}, vec_req, 0);
    chk(svc_lvl === svc, {tag, " svc kept"}, svc_lvl, svc);
  endtask

  task automatic ret_to(input string tag, input logic [1:0] svc);
    req = '0; poll(1, 1, 0);
    chk(vec_req === 1'b0 && svc_lvl === svc, {tag, " R8 return"}, {vec_req, svc_lvl}, {1'b0, svc});
  endtask

  task automatic t_reset;
    chk(vec_req === 0 && flag_clr === '0 && svc_lvl === 2'b00, "R1 reset", {vec_req, flag_clr, svc_lvl}, 0);
  endtask

  task automatic t_enables;
    req = 8'h10; irq_en = 8'h00; glb_en = 1; prio_hi = '0;
    poll(1, 0, 0); expect_none("R3 source disabled", 2'b00);
    req = 8'h10; irq_en = 8'hFF; glb_en = 0;
    poll(1, 0, 0); expect_none("R3 global off", 2'b00);
    req = 8'h10; glb_en = 1;
    poll(1, 0, 0); expect_grant("R3 serial", 4, 8'h00, 2'b01);
    ret_to("serial", 2'b00);
  endtask

  task automatic t_order_edge;
    req = 8'h44; edge_mode = 8'h04; prio_hi = '0;
    poll(1, 0, 0); expect_grant("R4 lowest index edge ext", 2, 8'h04, 2'b01);
    ret_to("ext2", 2'b00);
    req = 8'h01; edge_mode = 8'h00;
    poll(1, 0, 0); expect_grant("R9 level ext kept", 0, 8'h00, 2'b01);
    ret_to("ext0", 2'b00);
  endtask

  task automatic t_priority;
    req = 8'h22; prio_hi = 8'h20;
    poll(1, 0, 0); expect_grant("R4 high over low", 5, 8'h00, 2'b10);
    req = 8'h02; poll(1, 0, 0); expect_none("R5 low under high", 2'b10);
    req = 8'h20; poll(1, 0, 0); expect_none("R5 high under high", 2'b10);
    ret_to("t2", 2'b00);
  endtask

  task automatic t_preempt;
    req = 8'h08; prio_hi = 8'h01; edge_mode = 8'h00;
    poll(1, 0, 0); expect_grant("R9 timer cleared", 3, 8'h08, 2'b01);
    req = 8'h80; poll(1, 0, 0); expect_none("R5 low under low", 2'b01);
    req = 8'h01; poll(1, 0, 0); expect_grant("R5 high preempts low", 0, 8'h00, 2'b11);
    req = 8'h08; poll(1, 0, 0); expect_none("R5 nested busy", 2'b11);
    ret_to("nest hi", 2'b01);
    ret_to("nest lo", 2'b00);
  endtask

  task automatic t_blocking;
    req = 8'h02; prio_hi = '0;
    poll(0, 0, 0); expect_none("R2 not last cycle", 2'b00);
    poll(1, 0, 1); expect_none("R11 control write", 2'b00);
    poll(1, 1, 0); expect_none("R8 return blocks, idle stays", 2'b00);
    req = 8'h00; poll(1, 0, 0); expect_none("R10 dropped request lost", 2'b00);
    req = 8'h02; poll(1, 0, 0); expect_grant("R2 timer0 after unblock", 1, 8'h02, 2'b01);
    ret_to("tmr0", 2'b00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_enables();
    t_order_edge();
    t_priority();
    t_preempt();
    t_blocking();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule